// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This block is the hazard-detection logic of a five-stage in-order pipeline. It watches the instruction in the execute stage and the instruction in the decode stage. When the execute-stage instruction is a memory load and its destination register is a source that the decode-stage instruction really reads, the loaded value does not exist yet. It only appears at the end of the memory stage, so it cannot reach the dependent instruction's execute stage in time.

In that case the block asks for one pipeline stall. The program counter and the fetch/decode register keep their contents. A bubble goes into the decode/execute register, with all its control fields cleared, so the bubble writes no register and no memory as it moves down the pipe. The dependent instruction stays two cycles in decode and enters execute one cycle late. Every instruction behind it slips by the same cycle. After the stall the load is in the memory/writeback register, and the forwarding network supplies the value. Instructions two and three places behind the load are covered by forwarding alone, so they cause no stall.

The decision is combinational from the stage fields. The only state is a single flag that records whether the previous cycle was a stall, and it caps every stall at one cycle.

Top module: `lu_interlock`

## Requirements
- R1: When `ex_mem_rd` is 1, `ex_dst` is nonzero, `id_src_used[0]` is 1 and source A (`id_src_idx[REG_W-1:0]`) equals `ex_dst`, and the previous cycle was not a stall, the block stalls in that same cycle.
- R2: The same rule applies to source B (`id_src_idx[2*REG_W-1:REG_W]`), qualified by `id_src_used[1]`.
- R3: A source whose use flag is 0 never causes a stall, even when its index equals `ex_dst`.
- R4: A load whose destination is register 0 never causes a stall.
- R5: When `ex_mem_rd` is 0, no stall occurs, whatever the register fields hold.
- R6: In a stall cycle the outputs are `pc_wr_en`=0, `ifid_wr_en`=0 and `idex_bubble`=1. In every other cycle they are 1, 1 and 0.
- R7: A stall lasts exactly one cycle. If the stall condition is still present in the cycle after a stall, that cycle does not stall. The cycle after it may stall again.
- R8: For the sequence LD R1 / DSUB using R1 / AND using R1 / OR using R1, the pipeline sees exactly one stall. DSUB enters decode/execute one cycle late, and AND and OR follow it back to back.
- R9: While `rst` is 1, no stall is requested, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_mem_rd | input | 1 | Execute-stage instruction reads data memory (load) |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| id_src_idx | input | NUM_SRC*REG_W | Decode-stage source register indices, source A in the low field |
| id_src_used | input | NUM_SRC | Per-source flag: the decode-stage instruction reads this source |
| pc_wr_en | output | 1 | Program counter update enable |
| ifid_wr_en | output | 1 | Fetch/decode register load enable |
| idex_bubble | output | 1 | Clear the control fields loaded into decode/execute |

## Verification
A wrong stall-history flag shows up in the cycle right after a stall. A flag stuck at stall suppresses every later stall, and a flag stuck at run allows a second stall in a row. Both show on `idex_bubble` within one cycle of the first load-use pair. A faulty source comparison or use-flag qualifier changes the outputs in the very cycle the decode fields are presented. The bench models the pipeline around the block and checks stage occupancy on every edge, so any extra or missing stall moves the dependent instruction's entry into execute by a cycle and is visible at once.

// File: rtl/lu_pkg.sv
package lu_pkg;

    localparam int REG_W_DEF   = 5;
    localparam int NUM_SRC_DEF = 2;

    // History of the previous cycle
    typedef enum logic {
        LU_RUN  = 1'b0,
        LU_HOLD = 1'b1
    } lu_state_e;

    // Control handed to the pipeline registers
    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
    } lu_ctrl_t;

    function automatic lu_ctrl_t lu_ctrl_for(input logic stall);
        lu_ctrl_t c;
        c.pc_we   = ~stall;
        c.ifid_we = ~stall;
        c.bubble  = stall;
        return c;
    endfunction

endpackage

// File: rtl/lu_src_cmp.sv
module lu_src_cmp #(
    parameter int REG_W = lu_pkg::REG_W_DEF
) (
    input  logic             load_live,
    input  logic [REG_W-1:0] load_dst,
    input  logic [REG_W-1:0] src_idx,
    input  logic             src_used,
    output logic             hit
);
    // A source depends on the load only when it is really read
    always_comb begin
        hit = load_live && src_used && (src_idx == load_dst);
    end
endmodule

// File: rtl/lu_stall_ctl.sv
module lu_stall_ctl
    import lu_pkg::*;
#(
    parameter int NUM_SRC = lu_pkg::NUM_SRC_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] hit_vec,
    output lu_ctrl_t           ctrl
);
    lu_state_e state_q;
    logic      stall;

    // At most one stall in a row: the cycle after a hold always runs
    always_comb begin
        stall = (|hit_vec) && (state_q == LU_RUN) && !rst;
        ctrl  = lu_ctrl_for(stall);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LU_RUN;
        end else begin
            state_q <= stall ? LU_HOLD : LU_RUN;
        end
    end
endmodule

// File: rtl/lu_interlock.sv
module lu_interlock
    import lu_pkg::*;
#(
    parameter int REG_W   = lu_pkg::REG_W_DEF,
    parameter int NUM_SRC = lu_pkg::NUM_SRC_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ex_mem_rd,
    input  logic [REG_W-1:0]         ex_dst,
    input  logic [NUM_SRC*REG_W-1:0] id_src_idx,
    input  logic [NUM_SRC-1:0]       id_src_used,
    output logic                     pc_wr_en,
    output logic                     ifid_wr_en,
    output logic                     idex_bubble
);
    logic               load_live;
    logic [NUM_SRC-1:0] hit_vec;
    lu_ctrl_t           ctrl;

    // Register 0 is hard-wired, so a load into it never creates a dependence
    always_comb begin
        load_live = ex_mem_rd && (ex_dst != '0);
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        lu_src_cmp #(.REG_W(REG_W)) i_cmp (
            .load_live (load_live),
            .load_dst  (ex_dst),
            .src_idx   (id_src_idx[g*REG_W +: REG_W]),
            .src_used  (id_src_used[g]),
            .hit       (hit_vec[g])
        );
    end

    lu_stall_ctl #(.NUM_SRC(NUM_SRC)) i_ctl (
        .clk     (clk),
        .rst     (rst),
        .hit_vec (hit_vec),
        .ctrl    (ctrl)
    );

    always_comb begin
        pc_wr_en    = ctrl.pc_we;
        ifid_wr_en  = ctrl.ifid_we;
        idex_bubble = ctrl.bubble;
    end
endmodule

// File: rtl/lu_interlock_chk.sv
module lu_interlock_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     ex_mem_rd,
    input logic [REG_W-1:0]         ex_dst,
    input logic [NUM_SRC*REG_W-1:0] id_src_idx,
    input logic [NUM_SRC-1:0]       id_src_used,
    input logic                     pc_wr_en,
    input logic                     ifid_wr_en,
    input logic                     idex_bubble
);
    logic dep_seen;
    logic prev_bubble;

    always_comb begin
        dep_seen = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (ex_mem_rd && ex_dst != '0 && id_src_used[s] &&
                id_src_idx[s*REG_W +: REG_W] == ex_dst) begin
                dep_seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_bubble <= 1'b0;
        else     prev_bubble <= idex_bubble;
    end

    // R1 and R2: a fresh dependence on either source stalls at once
    assert_dep_stall_R1: assert property (@(posedge clk) disable iff (rst)
        (dep_seen && !prev_bubble) |-> idex_bubble);

    assert_no_false_stall_R3: assert property (@(posedge clk) disable iff (rst)
        !dep_seen |-> !idex_bubble);

    assert_zero_dst_R4: assert property (@(posedge clk) disable iff (rst)
        (ex_dst == '0) |-> !idex_bubble);

    assert_nonload_R5: assert property (@(posedge clk) disable iff (rst)
        !ex_mem_rd |-> (pc_wr_en && ifid_wr_en));

    assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |-> (!pc_wr_en && !ifid_wr_en));

    assert_run_outputs_R6: assert property (@(posedge clk) disable iff (rst)
        !idex_bubble |-> (pc_wr_en && ifid_wr_en));

    assert_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |=> !idex_bubble);
endmodule

bind lu_interlock lu_interlock_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .ex_mem_rd   (ex_mem_rd),
    .ex_dst      (ex_dst),
    .id_src_idx  (id_src_idx),
    .id_src_used (id_src_used),
    .pc_wr_en    (pc_wr_en),
    .ifid_wr_en  (ifid_wr_en),
    .idex_bubble (idex_bubble)
);

// File: tb/test_lu_interlock.sv
module test_lu_interlock;

    localparam int REG_W   = 5;
    localparam int NUM_SRC = 2;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     ex_mem_rd = 1'b0;
    logic [REG_W-1:0]         ex_dst = '0;
    logic [NUM_SRC*REG_W-1:0] id_src_idx = '0;
    logic [NUM_SRC-1:0]       id_src_used = '0;
    logic                     pc_wr_en;
    logic                     ifid_wr_en;
    logic                     idex_bubble;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    lu_interlock #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_lu_interlock (
        .clk(clk), .rst(rst), .ex_mem_rd(ex_mem_rd), .ex_dst(ex_dst),
        .id_src_idx(id_src_idx), .id_src_used(id_src_used),
        .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en), .idex_bubble(idex_bubble)
    );

    typedef struct packed {
        logic             ld;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] sa;
        logic [REG_W-1:0] sb;
        logic             ua;
        logic             ub;
    } ins_t;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected {pc_wr_en, ifid_wr_en, idex_bubble}: stall = 3'b001, run = 3'b110
    task automatic chk_ctrl(input string req, input logic stall);
        chk(req, int'({pc_wr_en, ifid_wr_en, idex_bubble}), stall ? 1 : 6);
    endtask

    task automatic drive(input logic ld, input logic [REG_W-1:0] dst,
                         input logic [REG_W-1:0] sa, input logic ua,
                         input logic [REG_W-1:0] sb, input logic ub);
        ex_mem_rd   = ld;
        ex_dst      = dst;
        id_src_idx  = {sb, sa};
        id_src_used = {ub, ua};
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        drive(1'b0, '0, '0, 1'b0, '0, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(1'b1, 5'd3, 5'd3, 1'b1, 5'd3, 1'b1);
        #1 chk_ctrl("R9 no stall during reset", 1'b0);
        @(negedge clk);
        #1 chk_ctrl("R9 no stall during reset, second cycle", 1'b0);
        drive(1'b0, '0, '0, 1'b0, '0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        #1 chk_ctrl("R9 run outputs after reset", 1'b0);
    endtask

    task automatic t_src_a();
        idle_cycle();
        drive(1'b1, 5'd7, 5'd7, 1'b1, 5'd2, 1'b1);
        #1 chk_ctrl("R1 source A match stalls", 1'b1);
        chk("R6 bubble asserted", int'(idex_bubble), 1);
        chk("R6 pc held", int'(pc_wr_en), 0);
    endtask

    task automatic t_src_b();
        idle_cycle();
        drive(1'b1, 5'd31, 5'd4, 1'b1, 5'd31, 1'b1);
        #1 chk_ctrl("R2 source B match stalls", 1'b1);
        chk("R6 fetch/decode held", int'(ifid_wr_en), 0);
    endtask

    task automatic t_use_flags();
        idle_cycle();
        drive(1'b1, 5'd9, 5'd9, 1'b0, 5'd9, 1'b0);
        #1 chk_ctrl("R3 unused sources ignored", 1'b0);
        @(negedge clk);
        drive(1'b1, 5'd9, 5'd9, 1'b0, 5'd1, 1'b1);
        #1 chk_ctrl("R3 unused A match, used B mismatch", 1'b0);
    endtask

    task automatic t_zero_dst();
        idle_cycle();
        drive(1'b1, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        #1 chk_ctrl("R4 load into register 0 ignored", 1'b0);
    endtask

    task automatic t_not_load();
        idle_cycle();
        drive(1'b0, 5'd12, 5'd12, 1'b1, 5'd12, 1'b1);
        #1 chk_ctrl("R5 non-load producer ignored", 1'b0);
    endtask

    task automatic t_back_to_back();
        idle_cycle();
        drive(1'b1, 5'd5, 5'd5, 1'b1, 5'd0, 1'b0);
        #1 chk_ctrl("R7 first cycle stalls", 1'b1);
        @(negedge clk);
        #1 chk_ctrl("R7 held condition does not stall again", 1'b0);
        @(negedge clk);
        #1 chk_ctrl("R7 stall allowed again afterwards", 1'b1);
    endtask

    function automatic ins_t fetch(input int idx);
        ins_t i;
        i = '0;
        case (idx)
            0: i = '{ld:1'b1, dst:5'd1, sa:5'd2, sb:5'd0, ua:1'b1, ub:1'b0}; // LD R1,0(R2)
            1: i = '{ld:1'b0, dst:5'd4, sa:5'd1, sb:5'd5, ua:1'b1, ub:1'b1}; // DSUB R4,R1,R5
            2: i = '{ld:1'b0, dst:5'd6, sa:5'd1, sb:5'd7, ua:1'b1, ub:1'b1}; // AND R6,R1,R7
            3: i = '{ld:1'b0, dst:5'd8, sa:5'd1, sb:5'd9, ua:1'b1, ub:1'b1}; // OR R8,R1,R9
            default: i = '0;
        endcase
        return i;
    endfunction

    task automatic t_sequence();
        int   exp_ifid [7] = '{0, 1, 1, 2, 3, -1, -1};
        int   exp_idex [7] = '{-1, 0, -1, 1, 2, 3, -1};
        int   pc = 0;
        int   ifid = -1;
        int   idex = -1;
        int   stalls = 0;
        logic s_pc, s_ifid, s_bub;
        ins_t e, d;
        idle_cycle();
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            e = fetch(idex);
            d = fetch(ifid);
            drive(e.ld, e.dst, d.sa, d.ua, d.sb, d.ub);
            #1;
            s_pc = pc_wr_en; s_ifid = ifid_wr_en; s_bub = idex_bubble;
            if (s_bub) stalls++;
            @(posedge clk);
            idex = s_bub ? -1 : ifid;
            if (s_ifid) ifid = (pc < 4) ? pc : -1;
            if (s_pc) pc++;
            chk($sformatf("R8 decode slot after edge %0d", k + 1), ifid, exp_ifid[k]);
            chk($sformatf("R8 execute slot after edge %0d", k + 1), idex, exp_idex[k]);
        end
        chk("R8 total stall cycles", stalls, 1);
    endtask

    initial begin
        int cycles = 0;
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_src_a();
        t_src_b();
        t_use_flags();
        t_zero_dst();
        t_not_load();
        t_back_to_back();
        t_sequence();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule